// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a bus-facing write port and the storage array of a parallel NOR flash model. Every write strobe carries an address and a data word; the sequencer interprets the low byte as a command or as the argument of a command already in progress. It tracks how far a multi-write sequence has advanced, keeps an 8-bit status byte, and selects which source a bus read should return: the array contents, the status byte, the identifier words or the query table.

Program, sector-erase and buffered-write sequences turn into one-cycle storage requests that carry an opcode, an address and a data word. A storage back end, outside this block, acts on those requests. A read-only input suppresses every storage request and raises a sticky error bit in place of each one. The sector length is a run-time input, given as the base-two logarithm of the sector size in address units. Erase addresses are rounded down to the start of their sector.

Top module: `nor_cmd_seq`

## Requirements
- R1: A synchronous reset clears the status byte, the pending command and the sequence position. After reset, `rd_mode` is 0 (array) and `req_valid` is 0.
- R2: In the idle position, bytes 0x00, 0xF0 and 0xFF return to array read (mode 0). Byte 0x50 clears all status bits and also returns to array read.
- R3: In the idle position, byte 0x70 selects status read (mode 1) and byte 0x90 selects identifier read (mode 2). Neither advances the sequence, so the next write is decoded as a new command.
- R4: Byte 0x10 or 0x40 arms a single program. The next write issues a program request (`req_op` 1) with that write's address and data, sets status bit 7 (ready) and returns to idle with mode 1. When `read_only` is high, no request is issued and status bit 4 (program error) is set.
- R5: Byte 0x20 immediately issues an erase request (`req_op` 2) with data all ones and the address rounded down to a multiple of 2^`sector_shift`, and sets bit 7. When read-only, it sets bit 5 (erase error) instead of issuing the request. The following write accepts 0xD0, which keeps mode 1 and returns to idle; any other byte returns to array read.
- R6: Byte 0x60 followed by 0xD0 or 0x01 sets bit 7, keeps mode 1 and returns to idle. Any other second byte returns to array read.
- R7: Byte 0x98 selects query read (mode 3). In query mode, 0xFF returns to array read and every other write leaves query mode in place.
- R8: Byte 0xE8 sets bit 7. The next write gives a count N, taken from the low COUNT_W bits of the data. The following N+1 writes each issue a buffer-word request (`req_op` 3) with their address and data and set bit 7. A further 0xD0 ends the sequence in mode 1; any other byte returns to array read. When read-only, the data writes issue no request and set bit 4.
- R9: An unrecognised command byte in the idle position returns to array read and leaves the status byte unchanged.
- R10: Error bits 4 and 5 are sticky. Later successful operations do not clear them; only a 0x50 command does.
- R11: A storage request is a single-cycle strobe in the cycle after its write strobe, with status bit 7 already set. Status and mode changes take effect on the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; low byte is the command |
| read_only | input | 1 | Suppresses storage requests and raises error bits |
| sector_shift | input | SHIFT_W | log2 of the sector length |
| rd_mode | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status byte (bit 7 ready, 5 erase error, 4 program error) |
| req_valid | output | 1 | Storage request strobe |
| req_op | output | 2 | Request opcode: 1 program, 2 erase, 3 buffer word |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |

## Verification
The bench drives status and identifier selection and then issues a further command, to catch a design that wrongly advances the sequence and swallows that command as an argument. It loads the buffered-write count with bits above COUNT_W set. A missing mask would produce extra buffer requests and treat the confirm byte as data. Erases are issued at mid-sector addresses, so an unaligned request address would show. Read-only runs check that no request escapes and that the error bits stay set through later successful operations, which exposes a design that clears them too early or writes regardless of the flag.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2,
        RM_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BUFW  = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ARG     = 2'd1,
        CYC_DATA    = 2'd2,
        CYC_CONFIRM = 2'd3
    } cyc_e;

    typedef enum logic [3:0] {
        CC_RESET,
        CC_CLRSTAT,
        CC_STATUS,
        CC_IDENT,
        CC_PROG,
        CC_ERASE,
        CC_LOCK,
        CC_QUERY,
        CC_BUFWR,
        CC_BAD
    } cmd_class_e;

    localparam logic [7:0] CMD_NONE     = 8'h00;
    localparam logic [7:0] CMD_PROG_A   = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_ERASE_B  = 8'h28;
    localparam logic [7:0] CMD_PROG_B   = 8'h40;
    localparam logic [7:0] CMD_CLRSTAT  = 8'h50;
    localparam logic [7:0] CMD_LOCK     = 8'h60;
    localparam logic [7:0] CMD_RDSTAT   = 8'h70;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_BUFWR    = 8'hE8;
    localparam logic [7:0] CMD_ALT_RST  = 8'hF0;
    localparam logic [7:0] CMD_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_LOCK_ALT = 8'h01;

    localparam int unsigned ST_READY_BIT = 7;
    localparam int unsigned ST_ERASE_BIT = 5;
    localparam int unsigned ST_PROG_BIT  = 4;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_seq_pkg::*;
(
    input  logic [7:0]  cmd_byte,
    input  logic [7:0]  cur_cmd,
    output cmd_class_e  cmd_class,
    output rd_mode_e    mode
);

    always_comb begin
        unique case (cmd_byte)
            CMD_NONE, CMD_ALT_RST, CMD_ARRAY: cmd_class = CC_RESET;
            CMD_CLRSTAT:                      cmd_class = CC_CLRSTAT;
            CMD_RDSTAT:                       cmd_class = CC_STATUS;
            CMD_IDENT:                        cmd_class = CC_IDENT;
            CMD_PROG_A, CMD_PROG_B:           cmd_class = CC_PROG;
            CMD_ERASE:                        cmd_class = CC_ERASE;
            CMD_LOCK:                         cmd_class = CC_LOCK;
            CMD_QUERY:                        cmd_class = CC_QUERY;
            CMD_BUFWR:                        cmd_class = CC_BUFWR;
            default:                          cmd_class = CC_BAD;
        endcase
    end

    always_comb begin
        unique case (cur_cmd)
            CMD_PROG_A, CMD_ERASE, CMD_ERASE_B, CMD_PROG_B,
            CMD_CLRSTAT, CMD_LOCK, CMD_RDSTAT, CMD_BUFWR: mode = RM_STATUS;
            CMD_IDENT:                                    mode = RM_IDENT;
            CMD_QUERY:                                    mode = RM_QUERY;
            default:                                      mode = RM_ARRAY;
        endcase
    end

endmodule

// File: rtl/nor_sector_align.sv
module nor_sector_align #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned SHIFT_W = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ADDR_W-1:0]  base
);

    logic [ADDR_W-1:0] keep;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign keep[i] = (i >= int'(shift));
    end

    assign base = addr & keep;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned COUNT_W = 8,
    localparam int unsigned SHIFT_W = $clog2(ADDR_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               read_only,
    input  logic [SHIFT_W-1:0] sector_shift,
    output logic [1:0]         rd_mode,
    output logic [7:0]         status,
    output logic               req_valid,
    output logic [1:0]         req_op,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]  req_data
);

    typedef struct packed {
        cyc_e               cyc;
        logic [7:0]         cmd;
        logic [7:0]         status;
        logic [COUNT_W-1:0] count;
        logic               req_valid;
        req_op_e            req_op;
        logic [ADDR_W-1:0]  req_addr;
        logic [DATA_W-1:0]  req_data;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [7:0]        byte_in;
    cmd_class_e        cls;
    rd_mode_e          mode;
    logic [ADDR_W-1:0] sector_base;

    assign byte_in = wr_data[7:0];

    nor_cmd_decode u_decode (
        .cmd_byte  (byte_in),
        .cur_cmd   (state_q.cmd),
        .cmd_class (cls),
        .mode      (mode)
    );

    nor_sector_align #(
        .ADDR_W  (ADDR_W),
        .SHIFT_W (SHIFT_W)
    ) u_align (
        .addr  (wr_addr),
        .shift (sector_shift),
        .base  (sector_base)
    );

    always_comb begin
        state_d           = state_q;
        state_d.req_valid = 1'b0;
        state_d.req_op    = OP_NONE;
        state_d.req_addr  = '0;
        state_d.req_data  = '0;

        if (wr_en) begin
            unique case (state_q.cyc)
                CYC_IDLE: begin
                    unique case (cls)
                        CC_RESET: begin
                            state_d.cmd = CMD_NONE;
                        end
                        CC_CLRSTAT: begin
                            state_d.status = '0;
                            state_d.cmd    = CMD_NONE;
                        end
                        CC_STATUS, CC_IDENT: begin
                            state_d.cmd = byte_in;
                        end
                        CC_PROG, CC_LOCK, CC_QUERY: begin
                            state_d.cmd = byte_in;
                            state_d.cyc = CYC_ARG;
                        end
                        CC_ERASE: begin
                            if (read_only) begin
                                state_d.status[ST_ERASE_BIT] = 1'b1;
                            end else begin
                                state_d.req_valid = 1'b1;
                                state_d.req_op    = OP_ERASE;
                                state_d.req_addr  = sector_base;
                                state_d.req_data  = '1;
                            end
                            state_d.status[ST_READY_BIT] = 1'b1;
                            state_d.cmd = byte_in;
                            state_d.cyc = CYC_ARG;
                        end
                        CC_BUFWR: begin
                            state_d.status[ST_READY_BIT] = 1'b1;
                            state_d.cmd = byte_in;
                            state_d.cyc = CYC_ARG;
                        end
                        default: begin
                            state_d.cmd = CMD_NONE;
                        end
                    endcase
                end

                CYC_ARG: begin
                    unique case (state_q.cmd)
                        CMD_PROG_A, CMD_PROG_B: begin
                            if (read_only) begin
                                state_d.status[ST_PROG_BIT] = 1'b1;
                            end else begin
                                state_d.req_valid = 1'b1;
                                state_d.req_op    = OP_PROG;
                                state_d.req_addr  = wr_addr;
                                state_d.req_data  = wr_data;
                            end
                            state_d.status[ST_READY_BIT] = 1'b1;
                            state_d.cyc = CYC_IDLE;
                        end
                        CMD_ERASE, CMD_ERASE_B: begin
                            if (byte_in == CMD_CONFIRM) begin
                                state_d.status[ST_READY_BIT] = 1'b1;
                            end else begin
                                state_d.cmd = CMD_NONE;
                            end
                            state_d.cyc = CYC_IDLE;
                        end
                        CMD_LOCK: begin
                            if (byte_in == CMD_CONFIRM || byte_in == CMD_LOCK_ALT) begin
                                state_d.status[ST_READY_BIT] = 1'b1;
                            end else begin
                                state_d.cmd = CMD_NONE;
                            end
                            state_d.cyc = CYC_IDLE;
                        end
                        CMD_QUERY: begin
                            if (byte_in == CMD_ARRAY) begin
                                state_d.cmd = CMD_NONE;
                                state_d.cyc = CYC_IDLE;
                            end
                        end
                        CMD_BUFWR: begin
                            state_d.count = wr_data[COUNT_W-1:0];
                            state_d.cyc   = CYC_DATA;
                        end
                        default: begin
                            state_d.cmd = CMD_NONE;
                            state_d.cyc = CYC_IDLE;
                        end
                    endcase
                end

                CYC_DATA: begin
                    if (state_q.cmd == CMD_BUFWR) begin
                        if (read_only) begin
                            state_d.status[ST_PROG_BIT] = 1'b1;
                        end else begin
                            state_d.req_valid = 1'b1;
                            state_d.req_op    = OP_BUFW;
                            state_d.req_addr  = wr_addr;
                            state_d.req_data  = wr_data;
                        end
                        state_d.status[ST_READY_BIT] = 1'b1;
                        if (state_q.count == '0) begin
                            state_d.cyc = CYC_CONFIRM;
                        end
                        state_d.count = state_q.count - 1'b1;
                    end else begin
                        state_d.cmd = CMD_NONE;
                        state_d.cyc = CYC_IDLE;
                    end
                end

                default: begin
                    if (state_q.cmd == CMD_BUFWR && byte_in == CMD_CONFIRM) begin
                        state_d.status[ST_READY_BIT] = 1'b1;
                    end else begin
                        state_d.cmd = CMD_NONE;
                    end
                    state_d.cyc = CYC_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_mode   = mode;
    assign status    = state_q.status;
    assign req_valid = state_q.req_valid;
    assign req_op    = state_q.req_op;
    assign req_addr  = state_q.req_addr;
    assign req_data  = state_q.req_data;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHIFT_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic               read_only,
    input logic [SHIFT_W-1:0] sector_shift,
    input logic [1:0]         rd_mode,
    input logic [7:0]         status,
    input logic               req_valid,
    input logic [1:0]         req_op,
    input logic [ADDR_W-1:0]  req_addr
);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (status == 8'h00 && rd_mode == 2'd0 && !req_valid));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7:0] == 8'h50 && rd_mode == 2'd0) |=> (status == 8'h00 && rd_mode == 2'd0));

    assert_no_req_ro_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !$past(read_only));

    assert_erase_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |-> ((req_addr & ~({ADDR_W{1'b1}} << sector_shift)) == '0));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(status[4]) || $fell(status[5])) |-> $past(wr_en && wr_data[7:0] == 8'h50));

    assert_req_follows_write_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($past(wr_en) && status[7]));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SHIFT_W (SHIFT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .read_only    (read_only),
    .sector_shift (sector_shift),
    .rd_mode      (rd_mode),
    .status       (status),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int SW = $clog2(AW) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          read_only = 1'b0;
    logic [SW-1:0] sector_shift = SW'(8);
    logic [1:0]    rd_mode;
    logic [7:0]    status;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .COUNT_W(8)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .read_only(read_only), .sector_shift(sector_shift), .rd_mode(rd_mode),
        .status(status), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data)
    );

    typedef struct packed {
        logic [23:0] addr;
        logic [15:0] data;
        logic [1:0]  mode;
        logic [7:0]  st;
        logic [1:0]  op;
        logic [23:0] raddr;
        logic [15:0] rdata;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{24'h000000, 16'h0070, 2'd1, 8'h00, 2'd0, 24'h0, 16'h0},       // R3 status select
        '{24'h000000, 16'h0090, 2'd2, 8'h00, 2'd0, 24'h0, 16'h0},       // R3 decoded as new cmd
        '{24'h000000, 16'h00FF, 2'd0, 8'h00, 2'd0, 24'h0, 16'h0},       // R2
        '{24'h000100, 16'h0040, 2'd1, 8'h00, 2'd0, 24'h0, 16'h0},       // R4 arm
        '{24'h000123, 16'hBEEF, 2'd1, 8'h80, 2'd1, 24'h000123, 16'hBEEF}, // R4 program
        '{24'h0002A7, 16'h0020, 2'd1, 8'h80, 2'd2, 24'h000200, 16'hFFFF}, // R5 aligned erase
        '{24'h000000, 16'h00D0, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R5 confirm
        '{24'h000000, 16'h0098, 2'd3, 8'h80, 2'd0, 24'h0, 16'h0},       // R7
        '{24'h000000, 16'h0012, 2'd3, 8'h80, 2'd0, 24'h0, 16'h0},       // R7 ignored
        '{24'h000000, 16'h00FF, 2'd0, 8'h80, 2'd0, 24'h0, 16'h0},       // R7 exit
        '{24'h000000, 16'h0060, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R6
        '{24'h000000, 16'h0001, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R6 alt second byte
        '{24'h000000, 16'h0060, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R6
        '{24'h000000, 16'h0033, 2'd0, 8'h80, 2'd0, 24'h0, 16'h0},       // R6 bad byte
        '{24'h000000, 16'h00E8, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R8
        '{24'h000000, 16'h0102, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R8 count masked to 2
        '{24'h000010, 16'h1111, 2'd1, 8'h80, 2'd3, 24'h000010, 16'h1111}, // R8
        '{24'h000012, 16'h2222, 2'd1, 8'h80, 2'd3, 24'h000012, 16'h2222}, // R8
        '{24'h000014, 16'h3333, 2'd1, 8'h80, 2'd3, 24'h000014, 16'h3333}, // R8 last word
        '{24'h000000, 16'h00D0, 2'd1, 8'h80, 2'd0, 24'h0, 16'h0},       // R8 confirm
        '{24'h000000, 16'h0050, 2'd0, 8'h00, 2'd0, 24'h0, 16'h0},       // R2 clear
        '{24'h000000, 16'h0055, 2'd0, 8'h00, 2'd0, 24'h0, 16'h0},       // R9 unknown
        '{24'h000000, 16'h00F0, 2'd0, 8'h00, 2'd0, 24'h0, 16'h0},       // R2
        '{24'h000000, 16'h0010, 2'd1, 8'h00, 2'd0, 24'h0, 16'h0},       // R4 arm alt
        '{24'h000005, 16'h1234, 2'd1, 8'h80, 2'd1, 24'h000005, 16'h1234}  // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [1:0] m, input logic [7:0] s, input logic [1:0] op);
        chk({tag, " mode"}, 32'(rd_mode), 32'(m));
        chk({tag, " status"}, 32'(status), 32'(s));
        chk({tag, " req_valid"}, 32'(req_valid), 32'(op != 2'd0));
        if (op != 2'd0) chk({tag, " req_op"}, 32'(req_op), 32'(op));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 2'd0, 8'h00, 2'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].data);
            expect_out($sformatf("table vec %0d", i), VEC[i].mode, VEC[i].st, VEC[i].op);
            if (VEC[i].op != 2'd0) begin
                chk($sformatf("table vec %0d req_addr", i), 32'(req_addr), 32'(VEC[i].raddr));
                chk($sformatf("table vec %0d req_data", i), 32'(req_data), 32'(VEC[i].rdata));
            end
        end

        // R2 clear, then R4 read-only program
        wr(0, 16'h0050);
        expect_out("R2 clear", 2'd0, 8'h00, 2'd0);
        read_only = 1'b1;
        wr(0, 16'h0040);
        wr(24'h30, 16'h5555);
        expect_out("R4 read-only program", 2'd1, 8'h90, 2'd0);

        // R10 error bit sticky across a good program
        read_only = 1'b0;
        wr(0, 16'h0040);
        wr(24'h32, 16'h6666);
        expect_out("R10 sticky program", 2'd1, 8'h90, 2'd1);

        // R5 read-only erase, then non-confirm byte abandons
        read_only = 1'b1;
        wr(24'h123, 16'h0020);
        expect_out("R5 read-only erase", 2'd1, 8'hB0, 2'd0);
        wr(0, 16'h0044);
        expect_out("R5 abandon", 2'd0, 8'hB0, 2'd0);
        read_only = 1'b0;

        // R8 count zero, one word, bad confirm
        wr(0, 16'h0050);
        wr(0, 16'h00E8);
        wr(0, 16'h0000);
        wr(24'h40, 16'hAAAA);
        expect_out("R8 single word", 2'd1, 8'h80, 2'd3);
        wr(0, 16'h0077);
        expect_out("R8 bad confirm", 2'd0, 8'h80, 2'd0);

        // R11 single-cycle strobe
        wr(0, 16'h0040);
        wr(24'h50, 16'h0F0F);
        chk("R11 strobe high", 32'(req_valid), 32'd1);
        @(negedge clk);
        chk("R11 strobe one cycle", 32'(req_valid), 32'd0);
        chk("R11 status held", 32'(status), 32'h80);

        // R8 read-only buffered write
        read_only = 1'b1;
        wr(0, 16'h0050);
        wr(0, 16'h00E8);
        wr(0, 16'h0000);
        wr(24'h60, 16'h1357);
        expect_out("R8 read-only word", 2'd1, 8'h90, 2'd0);
        wr(0, 16'h00D0);
        expect_out("R8 read-only confirm", 2'd1, 8'h90, 2'd0);
        read_only = 1'b0;

        // R3 status select does not consume the next command
        wr(0, 16'h0070);
        wr(0, 16'h0040);
        wr(24'h70, 16'h2468);
        expect_out("R3 no advance", 2'd1, 8'h90, 2'd1);

        // R1 mid-run reset
        wr(0, 16'h0098);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        expect_out("R1 mid-run reset", 2'd0, 8'h00, 2'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule